// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policies

This block sits between a processor's load/store port and the next memory level. The processor issues single-word reads and writes on a 32-bit byte address. Each request uses a valid/ready handshake and completes with a one-cycle response pulse. The controller keeps one entry per index. Each entry holds a stored tag, a valid flag, a dirty flag and one line of data. The controller decides hit or miss, then runs the eviction and refill sequence when needed.

The memory side has three independent transfer channels, each with its own valid/ready handshake:

- a whole-line read (refill), whose data returns in the handshake cycle;
- a whole-line write (eviction of a modified line);
- a single-word write (forwarding of a processor write).

Two elaboration parameters choose the behaviour of writes, and they are independent of each other:

- `WRITE_BACK` selects write-back or write-through handling of write hits.
- `WRITE_ALLOC` selects whether a write miss allocates a line.

The dirty state exists only when write-back handling is selected. Elaboration checks reject any geometry that is not a power of two.

Top module: `dmcache_ctrl`

## Requirements
- R1: A byte address splits into three fields. The low log2(LINE_BYTES) bits are the offset. The next log2(LINES) bits are the index. All remaining high bits are the tag. The 32-bit word inside a line is chosen by offset bits [OFF_W-1:2], with word 0 in line bits [31:0]. Address bits [1:0] are ignored, so a misaligned address accesses its aligned word.
- R2: After reset, `req_ready` is 1, `rsp_valid` is 0 and no memory channel is active. Every entry is invalid, so the first access to any index misses.
- R3: A lookup hits only when the indexed entry is valid and its stored tag equals the request tag. A read hit makes no memory transfer. `rsp_valid` rises in the cycle after acceptance with the addressed word, and `req_ready` stays 1 in that cycle.
- R4: On a read miss, a modified victim is first written out with a line-write transfer. Its address is {stored tag, index, zero offset} and it carries the whole line. The controller then makes a line-read transfer at {request tag, index, zero offset}, installs the line and responds with the requested word. `req_ready` is 0 from acceptance of a miss until its response.
- R5: With `WRITE_BACK`=1, a write hit changes only the cached line and marks it modified, with no memory transfer and a response in the next cycle. The modified data reaches memory when that line is later evicted.
- R6: With `WRITE_BACK`=0, every write is forwarded as one word-write transfer. The transfer carries the word-aligned address ({addr[31:2], 2'b00}) and the write data. Lines are never modified, and no line-write transfer ever occurs.
- R7: With `WRITE_ALLOC`=1, a write miss evicts the victim as in R4 and fetches the line. It then installs the line with the write merged in. In write-back mode the installed line is marked modified. In write-through mode the word write of R6 follows.
- R8: With `WRITE_ALLOC`=0, a write miss makes exactly one word-write transfer and leaves the cache unchanged. A later read of that address therefore misses and returns the memory's data.
- R9: At most one memory channel is active at a time. A channel's request (valid, address and data) is held stable until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| mem_rd_valid | output | 1 | Line-read request |
| mem_rd_ready | input | 1 | Line-read done; line data valid |
| mem_rd_addr | output | ADDR_W | Line-read address (zero offset) |
| mem_rd_line | input | LINE_BYTES*8 | Returned line |
| mem_wl_valid | output | 1 | Line-write request |
| mem_wl_ready | input | 1 | Line-write accepted |
| mem_wl_addr | output | ADDR_W | Line-write address (zero offset) |
| mem_wl_line | output | LINE_BYTES*8 | Line being written out |
| mem_ww_valid | output | 1 | Word-write request |
| mem_ww_ready | input | 1 | Word-write accepted |
| mem_ww_addr | output | ADDR_W | Word-aligned write address |
| mem_ww_data | output | 32 | Word being written |

## Verification
The bound checker watches the memory-side protocol on every cycle:

- only one channel is active at a time;
- each request is held stable until its ready;
- line addresses have a zero offset;
- no request is accepted while a transfer is pending;
- a line read always follows a victim write-back;
- in write-through mode, no line write is ever issued.

The checker also checks that every response pulse follows an acceptance or a final memory handshake.

Three properties can only be shown by the bench's address sweeps against an independent model of tags, contents and expected transfer counts:

- data correctness, including misaligned addresses;
- hit versus miss latency;
- the contents written back for modified lines, and the no-allocate property that a write miss leaves later reads missing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FILL,
      ST_FWD
   } dmc_state_e;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 5,
   parameter int IDX_W  = 10,
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
   localparam int WSEL_W = OFF_W - 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [IDX_W-1:0]  idx,
   output logic [WSEL_W-1:0] wsel
);

   logic unused_lsb;

   assign tag        = addr[ADDR_W-1 -: TAG_W];
   assign idx        = addr[OFF_W +: IDX_W];
   assign wsel       = addr[2 +: WSEL_W];
   assign unused_lsb = ^addr[1:0];

endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES      = 1024,
   parameter int TAG_W      = 17,
   parameter bit WITH_DIRTY = 1'b1,
   localparam int IDX_W     = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_dirty,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_dirty
);

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   generate
      if (WITH_DIRTY) begin : g_dirty
         logic [LINES-1:0] dirty_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dirty_q <= '0;
            end else if (wr_en) begin
               dirty_q[wr_idx] <= wr_dirty;
            end
         end
         assign rd_dirty = dirty_q[rd_idx];
      end else begin : g_clean
         logic unused_dirty;
         assign unused_dirty = wr_dirty;
         assign rd_dirty     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int LINES  = 1024,
   parameter int LINE_W = 256,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line
);

   logic [LINE_W-1:0] line_q [LINES];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         line_q[wr_idx] <= wr_line;
      end
   end

   assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/dmcache_ctrl.sv
module dmcache_ctrl
   import dmc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LINES       = 1024,
   parameter int LINE_BYTES  = 32,
   parameter bit WRITE_BACK  = 1'b1,
   parameter bit WRITE_ALLOC = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic                    rsp_valid,
   output logic [DATA_W-1:0]       rsp_rdata,
   output logic                    mem_rd_valid,
   input  logic                    mem_rd_ready,
   output logic [ADDR_W-1:0]       mem_rd_addr,
   input  logic [LINE_BYTES*8-1:0] mem_rd_line,
   output logic                    mem_wl_valid,
   input  logic                    mem_wl_ready,
   output logic [ADDR_W-1:0]       mem_wl_addr,
   output logic [LINE_BYTES*8-1:0] mem_wl_line,
   output logic                    mem_ww_valid,
   input  logic                    mem_ww_ready,
   output logic [ADDR_W-1:0]       mem_ww_addr,
   output logic [DATA_W-1:0]       mem_ww_data
);

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WSEL_W = OFF_W - 2;
   localparam int WORDS  = LINE_BYTES / 4;
   localparam int LINE_W = LINE_BYTES * 8;

   // elaboration-time geometry checks
   if (LINE_BYTES < 8 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 8");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] sel);
      pick_word = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (sel == WSEL_W'(i)) pick_word = line[i*DATA_W +: DATA_W];
      end
   endfunction

   function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                  input logic [WSEL_W-1:0] sel,
                                                  input logic [DATA_W-1:0] word);
      put_word = line;
      for (int i = 0; i < WORDS; i++) begin
         if (sel == WSEL_W'(i)) put_word[i*DATA_W +: DATA_W] = word;
      end
   endfunction

   dmc_state_e state_q, state_d;
   logic [ADDR_W-1:0] lat_addr_q;
   logic              lat_write_q;
   logic [DATA_W-1:0] lat_wdata_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   logic [TAG_W-1:0]  in_tag, lt_tag, rd_tag, tag_wtag;
   logic [IDX_W-1:0]  in_idx, lt_idx, rd_idx, tag_widx, data_widx;
   logic [WSEL_W-1:0] in_wsel, lt_wsel;
   logic              rd_valid, rd_dirty, tag_we, tag_wdirty, data_we;
   logic [LINE_W-1:0] rd_line, data_wline;
   logic              accept, hit, rsp_set;
   logic [DATA_W-1:0] rsp_word;

   dmc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) in_split_i (
      .addr(req_addr), .tag(in_tag), .idx(in_idx), .wsel(in_wsel));

   dmc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) lt_split_i (
      .addr(lat_addr_q), .tag(lt_tag), .idx(lt_idx), .wsel(lt_wsel));

   assign rd_idx = (state_q == ST_IDLE) ? in_idx : lt_idx;

   dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .WITH_DIRTY(WRITE_BACK)) tag_i (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
      .rd_dirty(rd_dirty), .wr_en(tag_we), .wr_idx(tag_widx), .wr_tag(tag_wtag),
      .wr_dirty(tag_wdirty));

   dmc_data_store #(.LINES(LINES), .LINE_W(LINE_W)) data_i (
      .clk(clk), .rd_idx(rd_idx), .rd_line(rd_line), .wr_en(data_we),
      .wr_idx(data_widx), .wr_line(data_wline));

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign hit       = rd_valid && (rd_tag == in_tag);

   always_comb begin
      state_d    = state_q;
      rsp_set    = 1'b0;
      rsp_word   = '0;
      tag_we     = 1'b0;
      tag_widx   = lt_idx;
      tag_wtag   = lt_tag;
      tag_wdirty = 1'b0;
      data_we    = 1'b0;
      data_widx  = lt_idx;
      data_wline = mem_rd_line;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               if (hit) begin
                  if (!req_write) begin
                     rsp_set  = 1'b1;
                     rsp_word = pick_word(rd_line, in_wsel);
                  end else begin
                     data_we    = 1'b1;
                     data_widx  = in_idx;
                     data_wline = put_word(rd_line, in_wsel, req_wdata);
                     if (WRITE_BACK) begin
                        tag_we     = 1'b1;
                        tag_widx   = in_idx;
                        tag_wtag   = in_tag;
                        tag_wdirty = 1'b1;
                        rsp_set    = 1'b1;
                     end else begin
                        state_d = ST_FWD;
                     end
                  end
               end else if (req_write && !WRITE_ALLOC) begin
                  state_d = ST_FWD;
               end else if (rd_valid && rd_dirty) begin
                  state_d = ST_EVICT;
               end else begin
                  state_d = ST_FILL;
               end
            end
         end
         ST_EVICT: begin
            if (mem_wl_ready) state_d = ST_FILL;
         end
         ST_FILL: begin
            if (mem_rd_ready) begin
               tag_we     = 1'b1;
               data_we    = 1'b1;
               tag_wdirty = WRITE_BACK && lat_write_q;
               data_wline = lat_write_q ? put_word(mem_rd_line, lt_wsel, lat_wdata_q)
                                        : mem_rd_line;
               if (lat_write_q && !WRITE_BACK) begin
                  state_d = ST_FWD;
               end else begin
                  state_d  = ST_IDLE;
                  rsp_set  = 1'b1;
                  rsp_word = lat_write_q ? '0 : pick_word(mem_rd_line, lt_wsel);
               end
            end
         end
         ST_FWD: begin
            if (mem_ww_ready) begin
               state_d = ST_IDLE;
               rsp_set = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
         lat_addr_q  <= '0;
         lat_write_q <= 1'b0;
         lat_wdata_q <= '0;
      end else begin
         state_q     <= state_d;
         rsp_valid_q <= rsp_set;
         if (rsp_set) rsp_rdata_q <= rsp_word;
         if (accept) begin
            lat_addr_q  <= req_addr;
            lat_write_q <= req_write;
            lat_wdata_q <= req_wdata;
         end
      end
   end

   assign rsp_valid    = rsp_valid_q;
   assign rsp_rdata    = rsp_rdata_q;
   assign mem_wl_valid = (state_q == ST_EVICT);
   assign mem_wl_addr  = {rd_tag, lt_idx, {OFF_W{1'b0}}};
   assign mem_wl_line  = rd_line;
   assign mem_rd_valid = (state_q == ST_FILL);
   assign mem_rd_addr  = {lt_tag, lt_idx, {OFF_W{1'b0}}};
   assign mem_ww_valid = (state_q == ST_FWD);
   assign mem_ww_addr  = {lat_addr_q[ADDR_W-1:2], 2'b00};
   assign mem_ww_data  = lat_wdata_q;

endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
   parameter int ADDR_W      = 32,
   parameter int LINES       = 1024,
   parameter int LINE_BYTES  = 32,
   parameter bit WRITE_BACK  = 1'b1,
   parameter bit WRITE_ALLOC = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic                    req_write,
   input logic [ADDR_W-1:0]       req_addr,
   input logic [31:0]             req_wdata,
   input logic                    rsp_valid,
   input logic [31:0]             rsp_rdata,
   input logic                    mem_rd_valid,
   input logic                    mem_rd_ready,
   input logic [ADDR_W-1:0]       mem_rd_addr,
   input logic [LINE_BYTES*8-1:0] mem_rd_line,
   input logic                    mem_wl_valid,
   input logic                    mem_wl_ready,
   input logic [ADDR_W-1:0]       mem_wl_addr,
   input logic [LINE_BYTES*8-1:0] mem_wl_line,
   input logic                    mem_ww_valid,
   input logic                    mem_ww_ready,
   input logic [ADDR_W-1:0]       mem_ww_addr,
   input logic [31:0]             mem_ww_data
);

   localparam int OFF_W = $clog2(LINE_BYTES);

   // R9
   one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_valid, mem_wl_valid, mem_ww_valid}));

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R9
   wl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wl_valid && !mem_wl_ready) |=>
         (mem_wl_valid && $stable(mem_wl_addr) && $stable(mem_wl_line)));

   // R9
   ww_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ww_valid && !mem_ww_ready) |=>
         (mem_ww_valid && $stable(mem_ww_addr) && $stable(mem_ww_data)));

   // R4
   line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid || mem_wl_valid) |->
         ((mem_rd_valid ? mem_rd_addr[OFF_W-1:0] : mem_wl_addr[OFF_W-1:0]) == '0));

   // R4
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid || mem_wl_valid || mem_ww_valid) |-> !req_ready);

   // R4
   evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wl_valid && mem_wl_ready) |=> mem_rd_valid);

   // R3
   rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rd_valid && mem_rd_ready)
                     || $past(mem_ww_valid && mem_ww_ready)));

   generate
      if (!WRITE_BACK) begin : g_wt
         // R6
         wt_no_line_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mem_wl_valid);
      end
   endgenerate

   logic unused_chk;
   assign unused_chk = ^{req_write, req_addr, req_wdata, rsp_rdata, mem_rd_line, WRITE_ALLOC};

endmodule

bind dmcache_ctrl dmc_chk #(
   .ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES),
   .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
) chk_i (.*);

// File: tb/dmcache_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmcache_ctrl_tb_top;

   localparam int NL = 4;
   localparam int LB = 16;
   localparam int LW = LB * 8;
   localparam int NW = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        req_valid [2];
   logic        req_ready [2];
   logic        req_write [2];
   logic [31:0] req_addr  [2];
   logic [31:0] req_wdata [2];
   logic        rsp_valid [2];
   logic [31:0] rsp_rdata [2];
   logic        mem_rd_valid [2];
   logic        mem_rd_ready [2];
   logic [31:0] mem_rd_addr  [2];
   logic [LW-1:0] mem_rd_line [2];
   logic        mem_wl_valid [2];
   logic        mem_wl_ready [2];
   logic [31:0] mem_wl_addr  [2];
   logic [LW-1:0] mem_wl_line [2];
   logic        mem_ww_valid [2];
   logic        mem_ww_ready [2];
   logic [31:0] mem_ww_addr  [2];
   logic [31:0] mem_ww_data  [2];

   dmcache_ctrl #(.ADDR_W(32), .LINES(NL), .LINE_BYTES(LB), .WRITE_BACK(1'b1),
                  .WRITE_ALLOC(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
      .req_write(req_write[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
      .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]),
      .mem_rd_valid(mem_rd_valid[0]), .mem_rd_ready(mem_rd_ready[0]),
      .mem_rd_addr(mem_rd_addr[0]), .mem_rd_line(mem_rd_line[0]),
      .mem_wl_valid(mem_wl_valid[0]), .mem_wl_ready(mem_wl_ready[0]),
      .mem_wl_addr(mem_wl_addr[0]), .mem_wl_line(mem_wl_line[0]),
      .mem_ww_valid(mem_ww_valid[0]), .mem_ww_ready(mem_ww_ready[0]),
      .mem_ww_addr(mem_ww_addr[0]), .mem_ww_data(mem_ww_data[0]));

   dmcache_ctrl #(.ADDR_W(32), .LINES(NL), .LINE_BYTES(LB), .WRITE_BACK(1'b0),
                  .WRITE_ALLOC(1'b0)) wt_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
      .req_write(req_write[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
      .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]),
      .mem_rd_valid(mem_rd_valid[1]), .mem_rd_ready(mem_rd_ready[1]),
      .mem_rd_addr(mem_rd_addr[1]), .mem_rd_line(mem_rd_line[1]),
      .mem_wl_valid(mem_wl_valid[1]), .mem_wl_ready(mem_wl_ready[1]),
      .mem_wl_addr(mem_wl_addr[1]), .mem_wl_line(mem_wl_line[1]),
      .mem_ww_valid(mem_ww_valid[1]), .mem_ww_ready(mem_ww_ready[1]),
      .mem_ww_addr(mem_ww_addr[1]), .mem_ww_data(mem_ww_data[1]));

   function automatic logic [31:0] init_word(int k, int w);
      return 32'hA500_0000 ^ (w * 32'h0001_0203) ^ (k << 28);
   endfunction

   // lower-level memory model, one per instance
   logic [31:0] mem [2][NW];
   int wcnt [2];
   int cnt_rl [2];
   int cnt_wl [2];
   int cnt_ww [2];
   logic [31:0] last_wl_addr [2];

   always_comb begin
      for (int k = 0; k < 2; k++) begin
         mem_rd_ready[k] = mem_rd_valid[k] && (wcnt[k] >= 2);
         mem_wl_ready[k] = mem_wl_valid[k] && (wcnt[k] >= 2);
         mem_ww_ready[k] = mem_ww_valid[k] && (wcnt[k] >= 2);
         for (int j = 0; j < LB / 4; j++) begin
            mem_rd_line[k][j*32 +: 32] = mem[k][((mem_rd_addr[k] >> 2) + j) % NW];
         end
      end
   end

   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            wcnt[k]   <= 0;
            cnt_rl[k] <= 0;
            cnt_wl[k] <= 0;
            cnt_ww[k] <= 0;
            last_wl_addr[k] <= '0;
            for (int w = 0; w < NW; w++) mem[k][w] <= init_word(k, w);
         end else begin
            if (mem_rd_ready[k] || mem_wl_ready[k] || mem_ww_ready[k]) wcnt[k] <= 0;
            else if (mem_rd_valid[k] || mem_wl_valid[k] || mem_ww_valid[k]) wcnt[k] <= wcnt[k] + 1;
            if (mem_rd_ready[k]) cnt_rl[k] <= cnt_rl[k] + 1;
            if (mem_wl_ready[k]) begin
               cnt_wl[k] <= cnt_wl[k] + 1;
               last_wl_addr[k] <= mem_wl_addr[k];
               for (int j = 0; j < LB / 4; j++)
                  mem[k][((mem_wl_addr[k] >> 2) + j) % NW] <= mem_wl_line[k][j*32 +: 32];
            end
            if (mem_ww_ready[k]) begin
               cnt_ww[k] <= cnt_ww[k] + 1;
               mem[k][(mem_ww_addr[k] >> 2) % NW] <= mem_ww_data[k];
            end
         end
      end
   end

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // independent reference model from the requirements
   logic [31:0] refm [2][NW];
   bit cv [2][NL];
   int ct [2][NL];
   bit cd [2][NL];

   task automatic access(int k, bit wr, int a, logic [31:0] d);
      bit wb = (k == 0);
      bit wa = (k == 0);
      int w = (a >> 2) % NW;
      int idx = (a >> 4) % NL;
      int tg = a >> 6;
      bit hit = cv[k][idx] && (ct[k][idx] == tg);
      int e_rl = 0, e_wl = 0, e_ww = 0;
      int victim = 0;
      bit fast;
      int b_rl, b_wl, b_ww, n;
      logic [31:0] got;
      if (!wr) begin
         if (!hit) begin
            if (cv[k][idx] && cd[k][idx]) begin e_wl = 1; victim = (ct[k][idx] << 6) | (idx << 4); end
            e_rl = 1;
         end
      end else if (hit) begin
         if (!wb) e_ww = 1;
      end else if (wa) begin
         if (cv[k][idx] && cd[k][idx]) begin e_wl = 1; victim = (ct[k][idx] << 6) | (idx << 4); end
         e_rl = 1;
         if (!wb) e_ww = 1;
      end else begin
         e_ww = 1;
      end
      fast = hit && !(wr && !wb);
      b_rl = cnt_rl[k]; b_wl = cnt_wl[k]; b_ww = cnt_ww[k];
      req_valid[k] = 1'b1; req_write[k] = wr; req_addr[k] = a; req_wdata[k] = d;
      while (!req_ready[k]) @(negedge clk);
      @(negedge clk);
      req_valid[k] = 1'b0;
      n = 0;
      while (!rsp_valid[k] && n < 200) begin @(negedge clk); n++; end
      got = rsp_rdata[k];
      if (fast) begin
         chk(n == 0, wr ? "R5 write-hit latency" : "R3 read-hit latency", n, 0);
         chk(req_ready[k] == 1'b1, "R3 ready after hit", req_ready[k], 1);
      end else begin
         chk(n > 0, "R4 miss/forward not single-cycle", n, 1);
      end
      if (!wr) chk(got == refm[k][w], "R1 R4 read data", got, refm[k][w]);
      chk({cnt_rl[k] - b_rl, cnt_wl[k] - b_wl, cnt_ww[k] - b_ww} == {e_rl, e_wl, e_ww},
          wb ? "R5 R7 transfer counts" : "R6 R8 transfer counts",
          {cnt_rl[k] - b_rl, cnt_wl[k] - b_wl, cnt_ww[k] - b_ww}, {e_rl, e_wl, e_ww});
      if (e_wl != 0) begin
         chk(last_wl_addr[k] == victim, "R4 victim address", last_wl_addr[k], victim);
         for (int j = 0; j < 4; j++)
            chk(mem[k][(victim >> 2) + j] == refm[k][(victim >> 2) + j], "R5 written-back data",
                mem[k][(victim >> 2) + j], refm[k][(victim >> 2) + j]);
      end
      if (e_rl != 0) begin
         cv[k][idx] = 1'b1; ct[k][idx] = tg; cd[k][idx] = wb && wr;
      end else if (wr && hit && wb) begin
         cd[k][idx] = 1'b1;
      end
      if (wr) begin
         refm[k][w] = d;
         if (!wb) chk(mem[k][w] == d, "R6 forwarded word", mem[k][w], d);
      end
      @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < 2; k++) begin
         req_valid[k] = 1'b0; req_write[k] = 1'b0; req_addr[k] = '0; req_wdata[k] = '0;
         for (int w = 0; w < NW; w++) refm[k][w] = init_word(k, w);
         for (int i = 0; i < NL; i++) begin cv[k][i] = 1'b0; ct[k][i] = 0; cd[k][i] = 1'b0; end
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk(req_ready[k] == 1'b1, "R2 ready after reset", req_ready[k], 1);
         chk(rsp_valid[k] == 1'b0, "R2 no response after reset", rsp_valid[k], 0);
         chk({mem_rd_valid[k], mem_wl_valid[k], mem_ww_valid[k]} == 3'b000,
             "R2 memory idle after reset",
             {mem_rd_valid[k], mem_wl_valid[k], mem_ww_valid[k]}, 0);
      end
      for (int k = 0; k < 2; k++) begin
         // sweep reads with misaligned low bits (R1)
         for (int w = 0; w < NW; w++) access(k, 1'b0, w * 4 + (w & 3), 32'h0);
         // stride writes: hits and misses on every index (R5 R6 R7 R8)
         for (int w = 0; w < NW; w += 3)
            access(k, 1'b1, w * 4 + ((w >> 2) & 3), 32'hC0DE_0000 ^ (w * 7) ^ (k << 20));
         // reverse read sweep forces evictions of modified lines
         for (int w = NW - 1; w >= 0; w--) access(k, 1'b0, w * 4, 32'h0);
         // conflict pair on one index
         access(k, 1'b1, 32'h0000_0004, 32'h1234_5678 ^ k);
         access(k, 1'b0, 32'h0000_0044, 32'h0);
         access(k, 1'b0, 32'h0000_0005, 32'h0);
         access(k, 1'b1, 32'h0000_0008, 32'h0BAD_F00D);
         access(k, 1'b0, 32'h0000_000B, 32'h0);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R9 actual=hung expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule